// File: doc/BRIEF.md
# Slot Interrupt Router and Trigger

This block takes one interrupt request at a time from a device on the expansion bus, identified by its slot number and its interrupt pin (0 to 3). It turns the pair into an internal interrupt number using a fixed board map. It then drives a single upstream interrupt line. Each internal source has one bit in an edge mask and one bit in a polarity mask. An edge source produces a single-clock pulse. A level source sets the line to the value of its polarity bit.

Internal numbers begin at 32. The source index used to look up both masks is the routed number minus 32. A routed number below 32 (a pass-through slot) or at 64 and above has no mask bits and counts as a level source with polarity clear. The routed number and the line are both registered. They change one clock after the request strobe and keep their values until the next request.

Top module: `slot_irq_router`

## Requirements
- R1: While reset is low at a clock edge, `irq_line` becomes 0 and `route_num` becomes 0 at that edge.
- R2: A request from slot 5 with pin n gives `route_num` = 32 + n.
- R3: A request from slot 6 gives 36 for any pin, and a request from slot 7 gives 37 for any pin.
- R4: A request from a slot s in 8..12 with pin n gives 38 + (s - 8) + n.
- R5: A request from any slot outside 5..12 gives `route_num` equal to the pin number, 0 to 3.
- R6: `route_num` takes its new value at the clock edge that samples `req_valid` high, and it holds that value while no request is made.
- R7: If the edge-mask bit of the source index is 1, `irq_line` is 1 for exactly the one cycle after the request, then 0 until the next request.
- R8: If the edge-mask bit is 0 and the polarity bit is 1, `irq_line` goes to 1 one cycle after the request and holds 1 until the next request.
- R9: If both the edge-mask bit and the polarity bit are 0, `irq_line` goes to 0 one cycle after the request and holds 0 until the next request.
- R10: A routed number outside 32..63 reads 0 in both masks, so `irq_line` goes to 0 whatever the masks hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe that presents a request |
| req_slot | input | 5 | Slot number of the requesting device |
| req_pin | input | 2 | Interrupt pin of the device, 0 to 3 |
| edge_mask | input | 32 | Per-source edge select, indexed by routed number minus 32 |
| pol_mask | input | 32 | Per-source level polarity, same indexing |
| route_num | output | 8 | Registered internal interrupt number of the last request |
| irq_line | output | 1 | Upstream interrupt line |

## Verification
The assertions assume that the masks and the request fields are stable in the cycle that `req_valid` is high. They also assume the slot and pin are known values whenever the strobe is set. The bench changes every input only on the falling edge. It keeps the strobe to a single cycle and leaves at least two idle cycles after each request, so a pulse always finishes before the next request arrives. Random slots cover the whole 5-bit range, which includes the pass-through slots that the out-of-range rule handles.

// File: rtl/slot_irq_pkg.sv
// Package: shared constants for the slot interrupt router.
// Assumes: the board map below is fixed at design time.
package slot_irq_pkg;
    parameter int SLOT_W     = 5;   // slot number width
    parameter int PIN_W      = 2;   // interrupt pin width
    parameter int NUM_W      = 8;   // routed number width
    parameter int SRC_N      = 32;  // sources covered by the masks
    parameter int IRQ_BASE   = 32;  // first internal interrupt number
    parameter int SLOT_SB    = 5;   // multi-function bridge slot
    parameter int SLOT_GFX   = 6;   // graphics slot
    parameter int SLOT_NIC   = 7;   // network slot
    parameter int SLOT_EXP_LO = 8;  // first expansion slot
    parameter int SLOT_EXP_HI = 12; // last expansion slot
    parameter int GFX_LINE   = 4;   // offset for graphics slot
    parameter int NIC_LINE   = 5;   // offset for network slot
    parameter int EXP_LINE   = 6;   // offset of first expansion line
endpackage

// File: rtl/slot_irq_map.sv
// Module: combinational slot/pin to internal number map.
// Assumes: pin values are 0..3; slots outside the map pass the pin through.
module slot_irq_map
    import slot_irq_pkg::*;
#(
    parameter int S_W   = SLOT_W,
    parameter int P_W   = PIN_W,
    parameter int N_W   = NUM_W,
    parameter int SRC   = SRC_N,
    parameter int BASE  = IRQ_BASE,
    localparam int IDX_W = $clog2(SRC)
) (
    input  logic [S_W-1:0]   slot,
    input  logic [P_W-1:0]   pin,
    output logic [N_W-1:0]   routed,
    output logic             in_range,
    output logic [IDX_W-1:0] src_idx
);
    localparam logic [N_W-1:0] BASE_N = N_W'(BASE);
    localparam logic [N_W-1:0] TOP_N  = N_W'(BASE + SRC);

    logic [N_W-1:0] pin_n;
    logic [N_W-1:0] slot_n;

    assign pin_n  = N_W'(pin);
    assign slot_n = N_W'(slot);

    // Board map: choose the internal number from slot and pin.
    always_comb begin
        routed = pin_n;
        if (slot_n == N_W'(SLOT_SB)) begin
            routed = BASE_N + (pin_n & N_W'(3));
        end else if (slot_n == N_W'(SLOT_GFX)) begin
            routed = BASE_N + N_W'(GFX_LINE);
        end else if (slot_n == N_W'(SLOT_NIC)) begin
            routed = BASE_N + N_W'(NIC_LINE);
        end else if (slot_n >= N_W'(SLOT_EXP_LO) && slot_n <= N_W'(SLOT_EXP_HI)) begin
            routed = BASE_N + N_W'(EXP_LINE) + (slot_n - N_W'(SLOT_EXP_LO)) + pin_n;
        end
    end

    // Range check and mask index derivation.
    always_comb begin
        in_range = (routed >= BASE_N) && (routed < TOP_N);
        src_idx  = IDX_W'(routed - BASE_N);
    end
endmodule

// File: rtl/slot_irq_trig.sv
// Module: upstream line driver with edge pulse and held level.
// Assumes: one request at a time; a new request overrides a pending pulse end.
module slot_irq_trig
    import slot_irq_pkg::*;
#(
    parameter int SRC   = SRC_N,
    localparam int IDX_W = $clog2(SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             in_range,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [SRC-1:0]   edge_mask,
    input  logic [SRC-1:0]   pol_mask,
    output logic             line
);
    logic is_edge;
    logic pol_hi;
    logic line_q;
    logic pulse_q;

    // Mask lookup; out-of-range sources read as clear.
    always_comb begin
        is_edge = in_range && edge_mask[src_idx];
        pol_hi  = in_range && pol_mask[src_idx];
    end

    // Line register: pulse for edge sources, hold level otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else if (req) begin
            line_q  <= is_edge ? 1'b1 : pol_hi;
            pulse_q <= is_edge;
        end else if (pulse_q) begin
            line_q  <= 1'b0;
            pulse_q <= 1'b0;
        end
    end

    assign line = line_q;
endmodule

// File: rtl/slot_irq_router.sv
// Module: top of the slot interrupt router and trigger.
// Assumes: request fields and masks are valid while req_valid is high.
module slot_irq_router
    import slot_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [SLOT_W-1:0]   req_slot,
    input  logic [PIN_W-1:0]    req_pin,
    input  logic [SRC_N-1:0]    edge_mask,
    input  logic [SRC_N-1:0]    pol_mask,
    output logic [NUM_W-1:0]    route_num,
    output logic                irq_line
);
    localparam int IDX_W = $clog2(SRC_N);

    logic [NUM_W-1:0] routed;
    logic             in_range;
    logic [IDX_W-1:0] src_idx;
    logic [NUM_W-1:0] route_q;

    slot_irq_map #(
        .S_W(SLOT_W), .P_W(PIN_W), .N_W(NUM_W), .SRC(SRC_N), .BASE(IRQ_BASE)
    ) u_map (
        .slot     (req_slot),
        .pin      (req_pin),
        .routed   (routed),
        .in_range (in_range),
        .src_idx  (src_idx)
    );

    slot_irq_trig #(.SRC(SRC_N)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_valid),
        .in_range  (in_range),
        .src_idx   (src_idx),
        .edge_mask (edge_mask),
        .pol_mask  (pol_mask),
        .line      (irq_line)
    );

    // Capture the routed number of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (req_valid) begin
            route_q <= routed;
        end
    end

    assign route_num = route_q;
endmodule

// File: rtl/slot_irq_router_chk.sv
// Module: assertion checker bound to slot_irq_router.
// Assumes: observes top-level ports only.
module slot_irq_router_chk
    import slot_irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [SLOT_W-1:0]   req_slot,
    input logic [PIN_W-1:0]    req_pin,
    input logic [SRC_N-1:0]    edge_mask,
    input logic [SRC_N-1:0]    pol_mask,
    input logic [NUM_W-1:0]    route_num,
    input logic                irq_line
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (route_num == '0 && !irq_line));

    a_r2_bridge_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_slot == SLOT_W'(5)) |=> route_num == NUM_W'(32) + NUM_W'($past(req_pin)));

    a_r3_gfx_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_slot == SLOT_W'(6)) |=> route_num == NUM_W'(36));

    a_r3_nic_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_slot == SLOT_W'(7)) |=> route_num == NUM_W'(37));

    a_r6_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(route_num));

    a_r8_no_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !irq_line) |=> !irq_line);

    a_r10_passthru_low: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_slot < SLOT_W'(5) || req_slot > SLOT_W'(12))) |=> !irq_line);
endmodule

bind slot_irq_router slot_irq_router_chk u_chk (.*);

// File: tb/slot_irq_router_tb.sv
module slot_irq_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_slot = '0;
    logic [1:0]  req_pin = '0;
    logic [31:0] edge_mask = '0;
    logic [31:0] pol_mask = '0;
    logic [7:0]  route_num;
    logic        irq_line;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slot_irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
        .req_pin(req_pin), .edge_mask(edge_mask), .pol_mask(pol_mask),
        .route_num(route_num), .irq_line(irq_line)
    );

    function automatic int exp_route(int s, int p);
        if (s == 5) return 32 + (p % 4);
        if (s == 6) return 36;
        if (s == 7) return 37;
        if (s >= 8 && s <= 12) return 38 + (s - 8) + p;
        return p;
    endfunction

    function automatic string req_of(int s);
        if (s == 5) return "R2";
        if (s == 6 || s == 7) return "R3";
        if (s >= 8 && s <= 12) return "R4";
        return "R5";
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one request and check route and line over the following cycles.
    task automatic do_req(int s, int p, logic [31:0] em, logic [31:0] pm);
        int r;
        bit inr, ed, lvl;
        r   = exp_route(s, p);
        inr = (r >= 32 && r < 64);
        ed  = inr && em[r - 32];
        lvl = inr && pm[r - 32];
        @(negedge clk);
        req_valid = 1'b1; req_slot = 5'(s); req_pin = 2'(p);
        edge_mask = em; pol_mask = pm;
        @(negedge clk);
        req_valid = 1'b0;
        req_slot = 5'($urandom_range(0, 31)); req_pin = 2'($urandom_range(0, 3));
        check(req_of(s), int'(route_num), r);
        if (!inr) check("R10", int'(irq_line), 0);
        else if (ed) check("R7", int'(irq_line), 1);
        else if (lvl) check("R8", int'(irq_line), 1);
        else check("R9", int'(irq_line), 0);
        @(negedge clk);
        edge_mask = $urandom(); pol_mask = $urandom();
        check("R6", int'(route_num), r);
        if (ed) check("R7", int'(irq_line), 0);
        else check(lvl ? "R8" : "R9", int'(irq_line), int'(lvl));
        @(negedge clk);
        check(ed ? "R7" : (lvl ? "R8" : "R9"), int'(irq_line), int'(!ed && lvl));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", int'(route_num), 0);
        check("R1", int'(irq_line), 0);
        rst_n = 1'b1;
        // Directed corner cases.
        do_req(5, 3, 32'h0, 32'hFFFF_FFFF);      // R2 level high at 35
        do_req(6, 2, 32'h0000_0010, 32'h0);      // R3 edge pulse on 36
        do_req(7, 0, 32'h0, 32'h0000_0020);      // R3 level at 37
        do_req(8, 0, 32'h0, 32'h0000_0040);      // R4 lowest expansion
        do_req(12, 3, 32'h0000_2000, 32'h0);     // R4 highest, edge at 45
        do_req(4, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R10 pass-through
        do_req(13, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R5 and R10
        do_req(5, 0, 32'h0, 32'h0);              // R9 level low
        // Reset mid-run after a high level.
        do_req(7, 1, 32'h0, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(route_num), 0);
        check("R1", int'(irq_line), 0);
        rst_n = 1'b1;
        // Random requests over the whole slot range.
        for (int i = 0; i < 300; i++) begin
            do_req($urandom_range(0, 31), $urandom_range(0, 3), $urandom(), $urandom());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule